// File: doc/BRIEF.md
# Capacitive Touch Key Detection Processor

This block turns the stream of per-burst signal counts of one capacitive key into a debounced touched / not-touched state. A sample strobe delivers one 8-bit count per measurement burst. The block keeps a reference level for the key and forms the difference between that reference and the newest count. A key that gains capacitance (a finger) reads a lower count, so a positive difference means "more capacitance". The difference is exported as a signed value so that neighbouring suppression logic can compare key strengths.

A single state machine handles the key. `ST_CALIB` averages a few samples into the reference after reset or on a calibrate request and leaves on *cal complete* to `ST_IDLE`. In `ST_IDLE` the reference drifts slowly toward the signal, at different rates in each direction. A strong sample causes *candidate* to `ST_ONSET`, which either *confirms* into `ST_HELD` or is *broken* back to `ST_IDLE`. When onset needs only one sample, *instant confirm* goes straight from `ST_IDLE` to `ST_HELD`. From `ST_HELD` a weak sample causes *drop* to `ST_RELEASE`. There a strong-enough sample causes *recover* back to `ST_HELD`, and a run of weak samples causes *released* to `ST_IDLE`. Two timers force *recal* from any operating state to `ST_IDLE`. One covers a key held too long and the other covers a signal sitting well above the reference. A request or reset causes *restart* to `ST_CALIB`.

All timing windows count a millisecond tick input. The default parameters give 2000 ms and 500 ms drift periods, a 2000 ms decrease window, and 10 s and 60 s maximum on-durations.

Top module: `touch_key_proc`

## Requirements
- R1: After reset, or after a calibrate request, `calibrating` is 1, `touch` is 0 and `delta` is 0. The reference becomes the mean (sum shifted right by 2) of the next 4 strobed samples. `calibrating` goes to 0 on the edge that takes the 4th sample.
- R2: Outside calibration, `delta` equals reference minus the last strobed count, as 9-bit two's complement. A positive value means increased capacitance.
- R3: A sample is a touch candidate when its delta is at least 10. A sample with delta 9 or less during onset returns the key to idle and clears the count.
- R4: `touch` rises on the strobe of the 6th consecutive candidate sample when `fast_mode` is 0, and on the 2nd when `fast_mode` is 1.
- R5: While touched, a sample with delta of 8 or more counts as still touched (hysteresis of 2). Such a sample also cancels a release in progress.
- R6: `touch` falls on the 6th consecutive sample with delta below 8, whatever the value of `fast_mode`.
- R7: In idle, a sample with delta from 1 to 9 lowers the reference by exactly one count, provided at least 2000 ticks (the increase period) have passed since the last adjustment or the last zero-delta sample.
- R8: In idle, a sample with delta from −1 to −5 raises the reference by one count once at least 500 ticks (the decrease period) have passed.
- R9: A sample in idle with delta of −6 or less starts a 2000-tick window. Drift is suppressed during the window. On the last tick the reference is loaded with the last sample.
- R10: `maxon_sel` 0 selects a 10000-tick limit, 1 selects 60000 ticks, and 2 or 3 disables the limit. Once a key has been touched for the limit, the reference is loaded with the last sample and `touch` falls. The key then detects normally again.
- R11: `cal_req` forces `touch` to 0 on the next edge and restarts calibration, even from a touched state.
- R12: `touch` rises only on an edge where `sample_valid` was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_valid | input | 1 | Strobe: `sample_count` holds a new burst result |
| sample_count | input | 8 | Signal count of the burst |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| fast_mode | input | 1 | 1 selects the two-sample onset |
| maxon_sel | input | 2 | Maximum on-duration: 0 short, 1 long, 2/3 off |
| cal_req | input | 1 | Restart calibration |
| touch | output | 1 | Debounced touch state |
| delta | output | 9 | Signed reference minus last sample |
| calibrating | output | 1 | Calibration in progress |

## Verification
A wrong reference appears on `delta` on the edge after the strobe that caused it. A miscounted drift period or recalibration window appears as a one-count step on `delta` one tick early or late. A wrong integrator count appears on `touch` one sample early or late, on the exact strobe edge where the rise or fall is expected. A timer that fails to clear shows as a recalibration on the wrong tick after the key is touched again.

// File: rtl/touch_key_pkg.sv
package touch_key_pkg;

    typedef enum logic [2:0] {
        ST_CALIB   = 3'd0,
        ST_IDLE    = 3'd1,
        ST_ONSET   = 3'd2,
        ST_HELD    = 3'd3,
        ST_RELEASE = 3'd4
    } key_state_e;

    // Key is reported as touched in both held and releasing states.
    function automatic logic is_touched(input key_state_e s);
        return (s == ST_HELD) || (s == ST_RELEASE);
    endfunction

endpackage

// File: rtl/tkp_fsm.sv
module tkp_fsm
    import touch_key_pkg::*;
#(
    parameter int ONSET_NORMAL = 6,
    parameter int ONSET_FAST   = 2,
    parameter int RELEASE_CNT  = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sample_strobe,
    input  logic       cand_on,
    input  logic       cand_hold,
    input  logic       fast_mode,
    input  logic       recal,
    input  logic       cal_req,
    input  logic       cal_done,
    output key_state_e state_q,
    output logic       touched
);

    localparam int CNT_MAX0 = (ONSET_NORMAL > ONSET_FAST) ? ONSET_NORMAL : ONSET_FAST;
    localparam int CNT_MAX  = (CNT_MAX0 > RELEASE_CNT) ? CNT_MAX0 : RELEASE_CNT;
    localparam int CNT_W    = $clog2(CNT_MAX + 1);

    key_state_e       state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc, need;

    assign cnt_inc = cnt_q + 1'b1;
    assign need    = fast_mode ? CNT_W'(ONSET_FAST) : CNT_W'(ONSET_NORMAL);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CALIB;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next-state and integrator
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (cal_req) begin
            state_d = ST_CALIB;
            cnt_d   = '0;
        end else if (recal) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
        end else if (sample_strobe) begin
            unique case (state_q)
                ST_CALIB: begin
                    if (cal_done) state_d = ST_IDLE;
                end
                ST_IDLE: begin
                    if (cand_on) begin
                        if (need <= CNT_W'(1)) begin
                            state_d = ST_HELD;
                            cnt_d   = '0;
                        end else begin
                            state_d = ST_ONSET;
                            cnt_d   = CNT_W'(1);
                        end
                    end
                end
                ST_ONSET: begin
                    if (!cand_on) begin
                        state_d = ST_IDLE;
                        cnt_d   = '0;
                    end else if (cnt_inc >= need) begin
                        state_d = ST_HELD;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_inc;
                    end
                end
                ST_HELD: begin
                    if (!cand_hold) begin
                        if (RELEASE_CNT <= 1) begin
                            state_d = ST_IDLE;
                            cnt_d   = '0;
                        end else begin
                            state_d = ST_RELEASE;
                            cnt_d   = CNT_W'(1);
                        end
                    end
                end
                ST_RELEASE: begin
                    if (cand_hold) begin
                        state_d = ST_HELD;
                        cnt_d   = '0;
                    end else if (cnt_inc >= CNT_W'(RELEASE_CNT)) begin
                        state_d = ST_IDLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_inc;
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        touched = is_touched(state_q);
    end

endmodule

// File: rtl/tkp_reference.sv
module tkp_reference
    import touch_key_pkg::*;
#(
    parameter int SAMPLE_W    = 8,
    parameter int CAL_SHIFT   = 2,
    parameter int DRIFT_UP_MS = 2000,
    parameter int DRIFT_DN_MS = 500
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  key_state_e                 state,
    input  logic                       sample_strobe,
    input  logic [SAMPLE_W-1:0]        sample,
    input  logic [SAMPLE_W-1:0]        last_sample,
    input  logic signed [SAMPLE_W:0]   delta_in,
    input  logic                       cand_on,
    input  logic                       drift_block,
    input  logic                       ms_tick,
    input  logic                       recal,
    input  logic                       cal_req,
    output logic [SAMPLE_W-1:0]        ref_q,
    output logic                       cal_done
);

    localparam int CAL_N  = 1 << CAL_SHIFT;
    localparam int SUM_W  = SAMPLE_W + CAL_SHIFT;
    localparam int CC_W   = (CAL_SHIFT > 0) ? CAL_SHIFT : 1;
    localparam int DT_MAX = (DRIFT_UP_MS > DRIFT_DN_MS) ? DRIFT_UP_MS : DRIFT_DN_MS;
    localparam int DT_W   = $clog2(DT_MAX + 1);

    logic [SUM_W-1:0] cal_sum, sum_next;
    logic [CC_W-1:0]  cal_cnt;
    logic [DT_W-1:0]  dcnt;
    logic             up_due, dn_due, d_pos, d_neg, drift_on;

    assign sum_next = cal_sum + SUM_W'(sample);
    assign cal_done = (state == ST_CALIB) && sample_strobe && !cal_req
                      && (cal_cnt == CC_W'(CAL_N - 1));
    assign up_due   = dcnt >= DT_W'(DRIFT_UP_MS);
    assign dn_due   = dcnt >= DT_W'(DRIFT_DN_MS);
    assign d_neg    = delta_in[SAMPLE_W];
    assign d_pos    = !d_neg && (delta_in != '0);
    assign drift_on = (state == ST_IDLE) && !drift_block;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q   <= '0;
            cal_sum <= '0;
            cal_cnt <= '0;
            dcnt    <= '0;
        end else if (cal_req) begin
            cal_sum <= '0;
            cal_cnt <= '0;
            dcnt    <= '0;
        end else if (recal) begin
            ref_q <= last_sample;
            dcnt  <= '0;
        end else if (state == ST_CALIB) begin
            dcnt <= '0;
            if (sample_strobe) begin
                if (cal_done) begin
                    ref_q   <= SAMPLE_W'(sum_next >> CAL_SHIFT);
                    cal_sum <= '0;
                    cal_cnt <= '0;
                end else begin
                    cal_sum <= sum_next;
                    cal_cnt <= cal_cnt + 1'b1;
                end
            end
        end else if (drift_on) begin
            if (sample_strobe) begin
                if (cand_on || (delta_in == '0)) begin
                    dcnt <= '0;
                end else if (d_pos && up_due) begin
                    ref_q <= ref_q - 1'b1;
                    dcnt  <= '0;
                end else if (d_neg && dn_due) begin
                    ref_q <= ref_q + 1'b1;
                    dcnt  <= '0;
                end
            end else if (ms_tick && (dcnt != DT_W'(DT_MAX))) begin
                dcnt <= dcnt + 1'b1;
            end
        end else begin
            dcnt <= '0;
        end
    end

endmodule

// File: rtl/tkp_recal_timers.sv
module tkp_recal_timers
    import touch_key_pkg::*;
#(
    parameter int NEG_RECAL_MS   = 2000,
    parameter int MAXON_SHORT_MS = 10000,
    parameter int MAXON_LONG_MS  = 60000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  key_state_e state,
    input  logic       sample_strobe,
    input  logic       neg_now,
    input  logic       ms_tick,
    input  logic [1:0] maxon_sel,
    input  logic       cal_req,
    output logic       neg_flag,
    output logic       recal
);

    localparam int NEG_W  = $clog2(NEG_RECAL_MS + 1);
    localparam int ON_MAX = (MAXON_SHORT_MS > MAXON_LONG_MS) ? MAXON_SHORT_MS : MAXON_LONG_MS;
    localparam int ON_W   = $clog2(ON_MAX + 1);

    logic [NEG_W-1:0] neg_cnt;
    logic [ON_W-1:0]  on_cnt, on_last;
    logic             touched, on_en, neg_fire, on_fire;

    assign touched  = is_touched(state);
    assign on_en    = !maxon_sel[1];
    assign on_last  = maxon_sel[0] ? ON_W'(MAXON_LONG_MS - 1) : ON_W'(MAXON_SHORT_MS - 1);
    assign neg_fire = neg_flag && (neg_cnt == NEG_W'(NEG_RECAL_MS - 1));
    assign on_fire  = touched && on_en && (on_cnt == on_last);
    assign recal    = !cal_req && ms_tick && (neg_fire || on_fire);

    // Decrease window
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            neg_flag <= 1'b0;
            neg_cnt  <= '0;
        end else begin
            if (cal_req || recal) begin
                neg_flag <= 1'b0;
            end else if (sample_strobe) begin
                neg_flag <= (state == ST_IDLE) && neg_now;
            end
            if (cal_req || recal || !neg_flag) begin
                neg_cnt <= '0;
            end else if (ms_tick) begin
                neg_cnt <= neg_cnt + 1'b1;
            end
        end
    end

    // Maximum on-duration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            on_cnt <= '0;
        end else if (cal_req || recal || !touched || !on_en) begin
            on_cnt <= '0;
        end else if (ms_tick) begin
            on_cnt <= on_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/touch_key_proc.sv
module touch_key_proc
    import touch_key_pkg::*;
#(
    parameter int SAMPLE_W        = 8,
    parameter int ON_THRESH       = 10,
    parameter int HYSTERESIS      = 2,
    parameter int NEG_RECAL_DELTA = 6,
    parameter int ONSET_NORMAL    = 6,
    parameter int ONSET_FAST      = 2,
    parameter int RELEASE_CNT     = 6,
    parameter int CAL_SHIFT       = 2,
    parameter int DRIFT_UP_MS     = 2000,
    parameter int DRIFT_DN_MS     = 500,
    parameter int NEG_RECAL_MS    = 2000,
    parameter int MAXON_SHORT_MS  = 10000,
    parameter int MAXON_LONG_MS   = 60000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sample_valid,
    input  logic [SAMPLE_W-1:0]        sample_count,
    input  logic                       ms_tick,
    input  logic                       fast_mode,
    input  logic [1:0]                 maxon_sel,
    input  logic                       cal_req,
    output logic                       touch,
    output logic signed [SAMPLE_W:0]   delta,
    output logic                       calibrating
);

    localparam int DW = SAMPLE_W + 1;
    localparam logic signed [DW-1:0] TH_ON   = DW'(ON_THRESH);
    localparam logic signed [DW-1:0] TH_HOLD = DW'(ON_THRESH - HYSTERESIS);
    localparam logic signed [DW-1:0] TH_NEG  = DW'(-NEG_RECAL_DELTA);

    key_state_e              state;
    logic [SAMPLE_W-1:0]     ref_lvl, last_sample;
    logic signed [DW-1:0]    delta_in, delta_last;
    logic                    cand_on, cand_hold, neg_now, neg_flag, recal, cal_done;

    assign delta_in   = $signed({1'b0, ref_lvl}) - $signed({1'b0, sample_count});
    assign delta_last = $signed({1'b0, ref_lvl}) - $signed({1'b0, last_sample});
    assign cand_on    = delta_in >= TH_ON;
    assign cand_hold  = delta_in >= TH_HOLD;
    assign neg_now    = delta_in <= TH_NEG;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_sample <= '0;
        end else if (sample_valid) begin
            last_sample <= sample_count;
        end
    end

    tkp_fsm #(
        .ONSET_NORMAL (ONSET_NORMAL),
        .ONSET_FAST   (ONSET_FAST),
        .RELEASE_CNT  (RELEASE_CNT)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .sample_strobe (sample_valid),
        .cand_on       (cand_on),
        .cand_hold     (cand_hold),
        .fast_mode     (fast_mode),
        .recal         (recal),
        .cal_req       (cal_req),
        .cal_done      (cal_done),
        .state_q       (state),
        .touched       (touch)
    );

    tkp_reference #(
        .SAMPLE_W    (SAMPLE_W),
        .CAL_SHIFT   (CAL_SHIFT),
        .DRIFT_UP_MS (DRIFT_UP_MS),
        .DRIFT_DN_MS (DRIFT_DN_MS)
    ) u_ref (
        .clk           (clk),
        .rst_n         (rst_n),
        .state         (state),
        .sample_strobe (sample_valid),
        .sample        (sample_count),
        .last_sample   (last_sample),
        .delta_in      (delta_in),
        .cand_on       (cand_on),
        .drift_block   (neg_flag || neg_now),
        .ms_tick       (ms_tick),
        .recal         (recal),
        .cal_req       (cal_req),
        .ref_q         (ref_lvl),
        .cal_done      (cal_done)
    );

    tkp_recal_timers #(
        .NEG_RECAL_MS   (NEG_RECAL_MS),
        .MAXON_SHORT_MS (MAXON_SHORT_MS),
        .MAXON_LONG_MS  (MAXON_LONG_MS)
    ) u_tmr (
        .clk           (clk),
        .rst_n         (rst_n),
        .state         (state),
        .sample_strobe (sample_valid),
        .neg_now       (neg_now),
        .ms_tick       (ms_tick),
        .maxon_sel     (maxon_sel),
        .cal_req       (cal_req),
        .neg_flag      (neg_flag),
        .recal         (recal)
    );

    // Outputs
    always_comb begin
        calibrating = (state == ST_CALIB);
        delta       = calibrating ? '0 : delta_last;
    end

endmodule

// File: rtl/touch_key_checker.sv
module touch_key_checker #(
    parameter int ON_DELTA = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sample_valid,
    input logic              ms_tick,
    input logic              cal_req,
    input logic              touch,
    input logic signed [8:0] delta,
    input logic              calibrating
);

    assert_cal_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        calibrating |-> !touch);

    assert_delta_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_valid && !ms_tick && !cal_req) |=> $stable(delta));

    assert_onset_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(touch) |-> (int'(delta) >= ON_DELTA));

    assert_fall_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(touch) |-> $past(sample_valid || ms_tick || cal_req));

    assert_cal_entry_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(calibrating) |-> $past(cal_req));

    assert_rise_on_sample_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(touch) |-> $past(sample_valid));

endmodule

bind touch_key_proc touch_key_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_valid (sample_valid),
    .ms_tick      (ms_tick),
    .cal_req      (cal_req),
    .touch        (touch),
    .delta        (delta),
    .calibrating  (calibrating)
);

// File: tb/touch_key_proc_bench.sv
module touch_key_proc_bench;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sample_valid = 1'b0;
    logic [7:0]        sample_count = 8'd0;
    logic              ms_tick = 1'b0;
    logic              fast_mode = 1'b0;
    logic [1:0]        maxon_sel = 2'd2;
    logic              cal_req = 1'b0;
    logic              touch;
    logic signed [8:0] delta_o;
    logic              calibrating;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    touch_key_proc #(
        .DRIFT_UP_MS    (8),
        .DRIFT_DN_MS    (2),
        .NEG_RECAL_MS   (6),
        .MAXON_SHORT_MS (20),
        .MAXON_LONG_MS  (40)
    ) u_touch_key_proc (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_valid (sample_valid),
        .sample_count (sample_count),
        .ms_tick      (ms_tick),
        .fast_mode    (fast_mode),
        .maxon_sel    (maxon_sel),
        .cal_req      (cal_req),
        .touch        (touch),
        .delta        (delta_o),
        .calibrating  (calibrating)
    );

    typedef struct packed {
        logic [7:0] smp;
        logic       fast;
        logic       exp_t;
        logic [3:0] req;
    } vec_t;

    // Reference is 100 for the whole table; expected delta = 100 - smp (R2).
    localparam int NV = 29;
    localparam vec_t VEC [NV] = '{
        '{8'd95,  1'b0, 1'b0, 4'd3},
        '{8'd90,  1'b0, 1'b0, 4'd4},
        '{8'd89,  1'b0, 1'b0, 4'd4},
        '{8'd90,  1'b0, 1'b0, 4'd4},
        '{8'd91,  1'b0, 1'b0, 4'd3},
        '{8'd90,  1'b0, 1'b0, 4'd4},
        '{8'd90,  1'b0, 1'b0, 4'd4},
        '{8'd90,  1'b0, 1'b0, 4'd4},
        '{8'd90,  1'b0, 1'b0, 4'd4},
        '{8'd90,  1'b0, 1'b0, 4'd4},
        '{8'd90,  1'b0, 1'b1, 4'd4},
        '{8'd92,  1'b0, 1'b1, 4'd5},
        '{8'd93,  1'b0, 1'b1, 4'd6},
        '{8'd93,  1'b0, 1'b1, 4'd6},
        '{8'd92,  1'b0, 1'b1, 4'd5},
        '{8'd95,  1'b0, 1'b1, 4'd6},
        '{8'd95,  1'b0, 1'b1, 4'd6},
        '{8'd95,  1'b0, 1'b1, 4'd6},
        '{8'd95,  1'b0, 1'b1, 4'd6},
        '{8'd95,  1'b0, 1'b1, 4'd6},
        '{8'd95,  1'b0, 1'b0, 4'd6},
        '{8'd90,  1'b1, 1'b0, 4'd4},
        '{8'd90,  1'b1, 1'b1, 4'd4},
        '{8'd100, 1'b1, 1'b1, 4'd6},
        '{8'd100, 1'b1, 1'b1, 4'd6},
        '{8'd100, 1'b1, 1'b1, 4'd6},
        '{8'd100, 1'b1, 1'b1, 4'd6},
        '{8'd100, 1'b1, 1'b1, 4'd6},
        '{8'd100, 1'b1, 1'b0, 4'd6}
    };

    function automatic string tag_of(input logic [3:0] r);
        case (r)
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            default: return "R2";
        endcase
    endfunction

    task automatic chk(input string tag, input logic t_exp, input int d_exp, input logic c_exp);
        n_vec++;
        if (touch !== t_exp || int'(delta_o) != d_exp || calibrating !== c_exp) begin
            n_bad++;
            $display("FAIL %s: touch=%0b delta=%0d cal=%0b, expected touch=%0b delta=%0d cal=%0b",
                     tag, touch, int'(delta_o), calibrating, t_exp, d_exp, c_exp);
        end
    endtask

    task automatic put_sample(input logic [7:0] s, input logic f);
        @(negedge clk);
        fast_mode    = f;
        sample_count = s;
        sample_valid = 1'b1;
        @(negedge clk);
        sample_valid = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            ms_tick = 1'b1;
            @(negedge clk);
            ms_tick = 1'b0;
        end
    endtask

    task automatic pulse_cal();
        @(negedge clk);
        cal_req = 1'b1;
        @(negedge clk);
        cal_req = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset", 1'b0, 0, 1'b1);
        rst_n = 1'b1;
        // R1: mean of 100,101,99,100 = 100
        put_sample(8'd100, 1'b0);
        put_sample(8'd101, 1'b0);
        put_sample(8'd99, 1'b0);
        chk("R1 still calibrating", 1'b0, 0, 1'b1);
        put_sample(8'd100, 1'b0);
        chk("R1 cal complete", 1'b0, 0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            put_sample(VEC[i].smp, VEC[i].fast);
            chk(tag_of(VEC[i].req), VEC[i].exp_t, 100 - int'(VEC[i].smp), 1'b0);
        end

        // R7: slow drift after 8 ticks, one count only
        put_sample(8'd97, 1'b0);
        chk("R7 no drift yet", 1'b0, 3, 1'b0);
        ticks(7);
        put_sample(8'd97, 1'b0);
        chk("R7 period not elapsed", 1'b0, 3, 1'b0);
        ticks(1);
        put_sample(8'd97, 1'b0);
        chk("R7 drift one count", 1'b0, 2, 1'b0);
        put_sample(8'd97, 1'b0);
        chk("R7 single step", 1'b0, 2, 1'b0);

        // R8: fast drift after 2 ticks (reference 99 -> 100)
        put_sample(8'd102, 1'b0);
        chk("R8 no drift yet", 1'b0, -3, 1'b0);
        ticks(1);
        put_sample(8'd102, 1'b0);
        chk("R8 period not elapsed", 1'b0, -3, 1'b0);
        ticks(1);
        put_sample(8'd102, 1'b0);
        chk("R8 drift one count", 1'b0, -2, 1'b0);

        // R9: decrease of 6 recalibrates after 6 ticks, drift suppressed
        put_sample(8'd106, 1'b0);
        chk("R9 window start", 1'b0, -6, 1'b0);
        ticks(3);
        put_sample(8'd106, 1'b0);
        chk("R9 drift suppressed", 1'b0, -6, 1'b0);
        ticks(2);
        chk("R9 before window end", 1'b0, -6, 1'b0);
        ticks(1);
        chk("R9 recalibrated", 1'b0, 0, 1'b0);

        // R10: short limit 20 ticks (reference 106)
        maxon_sel = 2'd0;
        put_sample(8'd96, 1'b1);
        put_sample(8'd96, 1'b1);
        chk("R4 fast onset", 1'b1, 10, 1'b0);
        ticks(19);
        chk("R10 short limit not reached", 1'b1, 10, 1'b0);
        ticks(1);
        chk("R10 short limit recal", 1'b0, 0, 1'b0);
        put_sample(8'd86, 1'b1);
        put_sample(8'd86, 1'b1);
        chk("R10 works after recal", 1'b1, 10, 1'b0);
        maxon_sel = 2'd2;
        ticks(45);
        chk("R10 disabled", 1'b1, 10, 1'b0);
        maxon_sel = 2'd1;
        ticks(39);
        chk("R10 long limit not reached", 1'b1, 10, 1'b0);
        ticks(1);
        chk("R10 long limit recal", 1'b0, 0, 1'b0);

        // R11: calibrate request from touched state (reference 86)
        put_sample(8'd76, 1'b1);
        put_sample(8'd76, 1'b1);
        chk("R11 touched before request", 1'b1, 10, 1'b0);
        pulse_cal();
        chk("R11 request forces release", 1'b0, 0, 1'b1);
        put_sample(8'd50, 1'b1);
        put_sample(8'd52, 1'b1);
        put_sample(8'd54, 1'b1);
        chk("R1 recal in progress", 1'b0, 0, 1'b1);
        put_sample(8'd56, 1'b1);
        chk("R1 new mean 53", 1'b0, -3, 1'b0);
        put_sample(8'd43, 1'b1);
        chk("R12 no rise on first sample", 1'b0, 10, 1'b0);
        put_sample(8'd43, 1'b1);
        chk("R11 normal after recal", 1'b1, 10, 1'b0);

        // R1: reset mid-touch
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 reset while touched", 1'b0, 0, 1'b1);
        rst_n = 1'b1;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule